// File: doc/BRIEF.md
# Synchronized Clock Output Stop Controller

This block gates a set of clock outputs on and off without glitches. Each output belongs to a CPU-, memory- or bus-class input clock, and its on/off choice comes from one bit of a configuration register: 1 lets the clock through, 0 stops it. A free-running reference clock is also passed through and is never gated. A fast sampling clock `clk` samples every input clock, so the gating is ordinary synchronous logic that can be synthesized and checked like any other logic.

When an output is turned off, its lane first waits for a rising edge of the reference clock. It then waits for the next falling edge of its own input clock, and from then on holds the output LOW. When the output is turned back on, the lane waits for a rising edge of its own input before it follows the clock again. As a result, every high pulse on an output lasts a full half period. Each lane has a status flag that is 1 only while its output is parked LOW.

Top module: `clkstop_top`

## Requirements
- R1: Output `clk_out[i]` follows `clk_in[i]` while `en_cfg[i]` is 1, and is disabled while `en_cfg[i]` is 0.
- R2: Reset is asynchronous and active low. During reset and immediately after it, every `clk_out` bit is 0 and every `parked` bit is 1.
- R3: After a disable, the output keeps toggling until the sampled reference clock shows a rising edge. While the reference is held still, the output never stops.
- R4: Once that reference rising edge has been seen, the output goes LOW at the next falling edge of its own input and stays LOW. An output only ever falls in step with its input falling.
- R5: Any subset of outputs can be stopped at once, up to all of them. Each stopped output parks independently.
- R6: `ref_clk_out` reproduces `ref_clk_in` 3 `clk` edges after the value is presented, whatever the enable bits are.
- R7: An output that is re-enabled resumes only at a rising edge of its own input. Every high pulse on `clk_out[i]` lasts at least one full half period of `clk_in[i]`.
- R8: A change on `en_cfg` passes through a two-flop synchronizer. The lane state machine acts on it at the third `clk` edge after the change is presented.
- R9: `parked[i]` is 1 exactly while output i is held LOW by the stop sequence, and stays 1 until the output restarts.
- R10: While running, `clk_out[i]` reproduces `clk_in[i]` 3 `clk` edges after the value is presented, so all outputs share the latency of `ref_clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| ref_clk_in | input | 1 | Free-running reference clock |
| clk_in | input | NUM_OUT | Input clocks to be gated |
| en_cfg | input | NUM_OUT | Per-output enable bits from the register domain (1 = run) |
| ref_clk_out | output | 1 | Ungated copy of the reference clock |
| clk_out | output | NUM_OUT | Gated clock outputs |
| parked | output | NUM_OUT | Per-output flag, 1 while that output is parked LOW |

## Verification
The assertions assume that every input clock, including the reference, holds each level for at least two `clk` periods. Under that assumption the sampled edges are exact, and pulse widths can be measured in sample cycles. The bench generates every clock from a counter that is advanced on the falling edge of `clk`. The half periods are 3 to 7 sampling cycles. The bench changes the enables only on that same falling edge. It also freezes the reference clock for a while to prove that no output stops before a reference rising edge.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WREF  = 3'd1,
    ST_WFALL = 3'd2,
    ST_PARK  = 3'd3,
    ST_WRISE = 3'd4
  } lane_st_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_hist.sv
module clkstop_hist #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic ref_rise,
  input  logic in_cur,
  input  logic in_prev,
  output logic gclk_out,
  output logic parked_o
);
  lane_st_t state_q, state_d;
  logic     out_q, out_d;
  logic     park_q, park_d;
  logic     in_rise, in_fall;

  assign in_rise = in_cur & ~in_prev;
  assign in_fall = ~in_cur & in_prev;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (!en_s) state_d = ST_WREF;
      ST_WREF:  if (en_s) state_d = ST_RUN;
                else if (ref_rise) state_d = ST_WFALL;
      ST_WFALL: if (en_s) state_d = ST_RUN;
                else if (in_fall) state_d = ST_PARK;
      ST_PARK:  if (en_s) state_d = ST_WRISE;
      ST_WRISE: if (!en_s) state_d = ST_PARK;
                else if (in_rise) state_d = ST_RUN;
      default:  state_d = ST_PARK;
    endcase
    out_d  = (state_d == ST_RUN || state_d == ST_WREF || state_d == ST_WFALL) ? in_cur : 1'b0;
    park_d = (state_d == ST_PARK || state_d == ST_WRISE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PARK;
      out_q   <= 1'b0;
      park_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
      park_q  <= park_d;
    end
  end

  assign gclk_out = out_q;
  assign parked_o = park_q;

  // R9: a parked lane never drives HIGH
  p_park_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    park_q |-> !out_q);

  // R4: the output only falls when its sampled input was low
  p_clean_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> !$past(in_cur));

  // R7: the output only rises on a rising edge of its input
  p_clean_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(in_cur) && !$past(in_prev)));

  // R8: parking is only entered with the synchronized enable low
  p_sync_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_q) |-> !$past(en_s));

  // R3: leaving the reference wait needs a reference rising edge or a re-enable
  p_ref_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WFALL && $past(state_q) == ST_WREF) |-> $past(ref_rise));
endmodule

// File: rtl/clkstop_top.sv
module clkstop_top #(
  parameter int NUM_OUT  = 3,
  parameter int EN_SYNC  = 2,
  parameter int CLK_SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk_in,
  input  logic [NUM_OUT-1:0] clk_in,
  input  logic [NUM_OUT-1:0] en_cfg,
  output logic               ref_clk_out,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] parked
);
  localparam int SW = NUM_OUT + 1;

  logic [SW-1:0]      smp_cur, smp_prev;
  logic [NUM_OUT-1:0] en_s;
  logic               ref_rise;
  logic               ref_q;

  clkstop_sync #(.W(SW), .STAGES(CLK_SYNC)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .d({ref_clk_in, clk_in}), .q(smp_cur));

  clkstop_sync #(.W(NUM_OUT), .STAGES(EN_SYNC)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(en_cfg), .q(en_s));

  clkstop_hist #(.W(SW)) u_hist (
    .clk(clk), .rst_n(rst_n), .cur(smp_cur), .prev(smp_prev));

  assign ref_rise = smp_cur[NUM_OUT] & ~smp_prev[NUM_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= smp_cur[NUM_OUT];
  end
  assign ref_clk_out = ref_q;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    clkstop_lane u_lane (
      .clk(clk), .rst_n(rst_n), .en_s(en_s[i]), .ref_rise(ref_rise),
      .in_cur(smp_cur[i]), .in_prev(smp_prev[i]),
      .gclk_out(clk_out[i]), .parked_o(parked[i]));
  end
endmodule

// File: tb/tb_clkstop_top.sv
`timescale 1ns/1ps
module tb_clkstop_top;
  localparam int N = 3;
  localparam int HALF [N] = '{3, 4, 5};
  localparam int RHALF = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_clk_in;
  logic [N-1:0] clk_in, en_cfg;
  logic ref_clk_out;
  logic [N-1:0] clk_out, parked;

  clkstop_top #(.NUM_OUT(N)) dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .clk_in(clk_in),
    .en_cfg(en_cfg), .ref_clk_out(ref_clk_out), .clk_out(clk_out), .parked(parked));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit ref_freeze = 0;
  int gcnt [N];
  int rcnt;
  // model history, index 0 newest
  logic [N-1:0] xq [4];
  logic         rq [4];
  logic [N-1:0] eq [4];
  int ph [N];
  logic [N-1:0] m_out, m_park;
  logic m_ref;
  int hl [N];
  int tg [N];
  int rtg;
  logic [N-1:0] last_out;
  logic last_ref;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin xq[k] = '0; rq[k] = 1'b0; eq[k] = '0; end
      for (int i = 0; i < N; i++) ph[i] = 3;
      m_out = '0; m_park = '1; m_ref = 1'b0;
      return;
    end
    for (int k = 3; k > 0; k--) begin xq[k] = xq[k-1]; rq[k] = rq[k-1]; eq[k] = eq[k-1]; end
    xq[0] = clk_in; rq[0] = ref_clk_in; eq[0] = en_cfg;
    for (int i = 0; i < N; i++) begin
      bit en = eq[2][i];   // R8: two-flop delay on the enable
      bit cur = xq[2][i], prv = xq[3][i];
      case (ph[i])
        0: if (!en) ph[i] = 1;
        1: if (en) ph[i] = 0; else if (rq[2] && !rq[3]) ph[i] = 2;
        2: if (en) ph[i] = 0; else if (!cur && prv) ph[i] = 3;
        3: if (en) ph[i] = 4;
        default: if (!en) ph[i] = 3; else if (cur && !prv) ph[i] = 0;
      endcase
      m_out[i]  = (ph[i] <= 2) ? cur : 1'b0;
      m_park[i] = (ph[i] >= 3);
    end
    m_ref = rq[2];
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    model_step();
    chk(ref_clk_out == m_ref, "R6", ref_clk_out, m_ref);
    for (int i = 0; i < N; i++) begin
      chk(clk_out[i] == m_out[i], "R10", clk_out[i], m_out[i]);
      chk(parked[i] == m_park[i], "R8,R9", parked[i], m_park[i]);
      if (clk_out[i] !== last_out[i]) tg[i]++;
      if (clk_out[i]) hl[i]++;
      else begin
        if (hl[i] > 0) chk(hl[i] >= HALF[i], "R7", hl[i], HALF[i]);
        hl[i] = 0;
      end
    end
    if (ref_clk_out !== last_ref) rtg++;
    last_out = clk_out; last_ref = ref_clk_out;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      gcnt[i]++;
      if (gcnt[i] >= HALF[i]) begin gcnt[i] = 0; clk_in[i] = ~clk_in[i]; end
    end
    if (!ref_freeze) begin
      rcnt++;
      if (rcnt >= RHALF) begin rcnt = 0; ref_clk_in = ~ref_clk_in; end
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic clr_tg();
    for (int i = 0; i < N; i++) tg[i] = 0;
    rtg = 0;
  endtask

  initial begin
    rst_n = 1'b0; ref_clk_in = 1'b0; clk_in = '0; en_cfg = '0;
    rcnt = 0; last_out = '0; last_ref = 1'b0;
    for (int i = 0; i < N; i++) begin gcnt[i] = 0; hl[i] = 0; tg[i] = 0; end
    rtg = 0;
    run(5);
    rst_n = 1'b1;
    run(1);
    chk(clk_out == '0, "R2", clk_out, 0);
    chk(parked == '1, "R2", parked, 7);
    // R1: enable everything
    en_cfg = '1;
    run(20);
    clr_tg();
    run(60);
    for (int i = 0; i < N; i++) chk(tg[i] > 4, "R1", tg[i], 5);
    // R3: freeze reference low, then disable lane 0
    while (ref_clk_in) run(1);
    ref_freeze = 1;
    en_cfg[0] = 1'b0;
    run(5);
    clr_tg();
    run(40);
    chk(tg[0] > 4, "R3", tg[0], 5);
    chk(parked[0] == 1'b0, "R3", parked[0], 0);
    // R4: release reference, lane 0 parks LOW
    ref_freeze = 0;
    run(30);
    clr_tg();
    run(30);
    chk(parked[0] == 1'b1, "R4", parked[0], 1);
    chk(tg[0] == 0 && clk_out[0] == 1'b0, "R4", tg[0], 0);
    // R7: re-enable lane 0
    en_cfg[0] = 1'b1;
    run(20);
    clr_tg();
    run(40);
    chk(tg[0] > 4, "R7", tg[0], 5);
    // R5: stop all outputs together
    en_cfg = '0;
    run(50);
    clr_tg();
    run(40);
    chk(parked == '1, "R5", parked, 7);
    chk(clk_out == '0, "R5", clk_out, 0);
    for (int i = 0; i < N; i++) chk(tg[i] == 0, "R5", tg[i], 0);
    chk(rtg > 4, "R6", rtg, 5);
    // subset: restart 1 and 2, stop 2 again quickly
    en_cfg = 3'b110;
    run(30);
    en_cfg = 3'b010;
    run(60);
    chk(parked == 3'b101, "R5", parked, 5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule